// File: doc/BRIEF.md
# Load/Store Alignment Exception Unit

This unit sits next to the load/store stage of a 32-bit big-endian RISC core. For every decoded memory instruction it decides in the same cycle whether the access must be abandoned with an alignment exception. The decision depends on the instruction class, the access width, the effective address, the write-through/cache-inhibit (WI) attribute of the translated page, the data-cache-enable bit and the little-endian mode bit of the machine state. When the decision is "trap", the load/store stage must suppress the access. This check comes before any split of an access that crosses a page.

Requests arrive on a valid/ready port. The unit never applies back-pressure: `req_ready` is held high, and a request is accepted on every clock edge where `req_valid` is high. Inputs are sampled only when a request is accepted. When an accepted request traps, the unit captures four values on that clock edge and raises `exc_pulse` for the following cycle. The captured values are the fault address, a syndrome word built from opcode and register fields, the handler vector, and the updated machine-state word.

Top module: `align_exc_unit`

## Requirements
- R1: The alignment mask is min(4, width/8) − 1 bytes. An 8-bit access is never misaligned. A 16-bit access is misaligned when address bit 0 is set. A 32-bit or 64-bit access is misaligned when either of address bits 1:0 is set.
- R2: A misaligned access traps only for these instruction classes:
  - floating load/store: primary 48..55;
  - multiword load/store: primary 46 or 47;
  - string: primary 31 with extended 533, 597, 661 or 725;
  - reserve/conditional store: primary 31 with extended 20 or 150;
  - external control: primary 31 with extended 310 or 438.
  
  A misaligned access of any other class, for example primary 32, does not trap.
- R3: Paired-single accesses count as floating only when the width is 32 with the selector bit at 1, or 64 with the selector bit at 0. The non-indexed forms (primary 56..61) use `req_w`. The indexed forms (primary 4, extended not 1014) use `req_wx`.
- R4: Cache-block-zero (extended 1014 with primary 31 or 4) traps when `req_wi` is 1, whatever the address alignment.
- R5: Cache-block-zero traps when `req_dce` is 0.
- R6: Multiword and string instructions trap whenever machine-state bit 0 (little-endian mode) is 1. Other classes are not affected by that bit.
- R7: On an accepted trapping request, `fault_addr` takes the full effective address. Otherwise it holds its value.
- R8: `syndrome` is formed from a 10-bit value op and the register fields:
  - op is the extended opcode if the primary opcode is 32 or more;
  - otherwise op is the primary opcode shifted right by one.
  
  The fields are placed as follows: op[9:8] at bits 16:15, op[4:0] at bits 14:10, RD at bits 9:5, RA at bits 4:0, and all other bits zero.
- R9: On an accepted trapping request, `handler_pc` becomes 0x00000600. `handler_msr` becomes the request's machine-state word with the bits in mask 0x04EF36 cleared and bit 0 replaced by bit 16.
- R10: `trap_now` is the combinational decision for the presented request. `exc_pulse` is high for exactly the one cycle after an accepted trapping request, and is low otherwise.
- R11: While `rst` is high at a clock edge, `exc_pulse`, `fault_addr`, `syndrome`, `handler_pc` and `handler_msr` become zero.
- R12: `req_ready` is always 1. A cycle with `req_valid` low raises no pulse and changes no captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1, no back-pressure |
| req_prim | input | 6 | Primary opcode |
| req_ext | input | 10 | Extended opcode |
| req_rd | input | 5 | Destination register field |
| req_ra | input | 5 | Base register field |
| req_w | input | 1 | Paired-single selector, non-indexed forms |
| req_wx | input | 1 | Paired-single selector, indexed forms |
| req_bits | input | 7 | Access width in bits (8, 16, 32, 64) |
| req_addr | input | 32 | Effective address |
| req_wi | input | 1 | Page is write-through or cache-inhibited |
| req_dce | input | 1 | Data cache enabled |
| req_msr | input | 32 | Current machine-state word |
| trap_now | output | 1 | Combinational trap decision, gated by valid |
| exc_pulse | output | 1 | One-cycle exception entry indication |
| fault_addr | output | 32 | Captured fault address |
| syndrome | output | 32 | Captured syndrome word |
| handler_pc | output | 32 | Captured handler vector |
| handler_msr | output | 32 | Machine-state word after entry |

## Verification
A wrong class decode or a wrong mask shows up on `trap_now` in the same cycle the request is presented. The bench therefore compares that output against its own decision for every request. A wrong capture register shows on `fault_addr`, `syndrome`, `handler_pc` or `handler_msr`, and a wrong pulse shows on `exc_pulse`. Both appear in the cycle right after the accepting edge. A capture that should have held its value is caught on the very next idle or non-trapping cycle.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int PRIM_W = 6;
  localparam int EXT_W  = 10;
  localparam int REG_W  = 5;
  localparam int BITS_W = 7;

  localparam logic [EXT_W-1:0] EXT_CBZ = 10'd1014;

  typedef struct packed {
    logic fp;       // floating or qualifying paired-single
    logic multi;    // multiword or string
    logic rsv;      // reserve / conditional store
    logic xctl;     // external control
    logic cbz;      // cache-block-zero
  } acc_class_t;

  function automatic logic is_string_ext(input logic [EXT_W-1:0] x);
    return (x == 10'd533) || (x == 10'd597) || (x == 10'd661) || (x == 10'd725);
  endfunction
endpackage

// File: rtl/align_classify.sv
module align_classify
  import align_pkg::*;
(
  input  logic [PRIM_W-1:0] prim,
  input  logic [EXT_W-1:0]  ext,
  input  logic              w_sel,
  input  logic              wx_sel,
  input  logic [BITS_W-1:0] bits,
  output acc_class_t        cls
);
  logic ps_ok_w, ps_ok_wx, fp_plain, fp_ps, fp_psx;

  always_comb begin
    ps_ok_w  = (bits == 7'd32 && w_sel)  || (bits == 7'd64 && !w_sel);
    ps_ok_wx = (bits == 7'd32 && wx_sel) || (bits == 7'd64 && !wx_sel);
    fp_plain = (prim >= 6'd48) && (prim <= 6'd55);
    fp_ps    = (prim >= 6'd56) && (prim <= 6'd61) && ps_ok_w;
    fp_psx   = (prim == 6'd4) && (ext != EXT_CBZ) && ps_ok_wx;
    cls.fp    = fp_plain || fp_ps || fp_psx;
    cls.multi = (prim == 6'd46) || (prim == 6'd47) ||
                ((prim == 6'd31) && is_string_ext(ext));
    cls.rsv   = (prim == 6'd31) && ((ext == 10'd20) || (ext == 10'd150));
    cls.xctl  = (prim == 6'd31) && ((ext == 10'd310) || (ext == 10'd438));
    cls.cbz   = (ext == EXT_CBZ) && ((prim == 6'd31) || (prim == 6'd4));
  end
endmodule

// File: rtl/align_misalign.sv
module align_misalign
  import align_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CAP_BYTES = 4
) (
  input  logic [BITS_W-1:0] bits,
  input  logic [ADDR_W-1:0] addr,
  output logic              misaligned
);
  localparam logic [BITS_W-1:0] CAP = BITS_W'(CAP_BYTES);

  logic [BITS_W-1:0] nbytes, span, mask;

  always_comb begin
    nbytes     = bits >> 3;
    span       = (nbytes > CAP) ? CAP : nbytes;
    mask       = (span == '0) ? '0 : span - 1'b1;
    misaligned = (addr & ADDR_W'(mask)) != '0;
  end
endmodule

// File: rtl/align_syndrome.sv
module align_syndrome
  import align_pkg::*;
#(
  parameter int SYN_W = 32
) (
  input  logic [PRIM_W-1:0] prim,
  input  logic [EXT_W-1:0]  ext,
  input  logic [REG_W-1:0]  rd,
  input  logic [REG_W-1:0]  ra,
  output logic [SYN_W-1:0]  syn
);
  logic       use_ext;
  logic [1:0] op_hi;
  logic [4:0] op_lo;

  always_comb begin
    use_ext = prim >= 6'd32;
    op_hi   = use_ext ? ext[9:8] : 2'b00;
    op_lo   = use_ext ? ext[4:0] : prim[5:1];
    syn     = '0;
    syn[16:15] = op_hi;
    syn[14:10] = op_lo;
    syn[9:5]   = rd;
    syn[4:0]   = ra;
  end
endmodule

// File: rtl/align_exc_unit.sv
module align_exc_unit
  import align_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          MSR_W     = 32,
  parameter int          CAP_BYTES = 4,
  parameter int          LE_BIT    = 0,
  parameter int          ILE_BIT   = 16,
  parameter logic [31:0] VECTOR    = 32'h0000_0600,
  parameter logic [31:0] MSR_CLR   = 32'h0004_EF36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [5:0]        req_prim,
  input  logic [9:0]        req_ext,
  input  logic [4:0]        req_rd,
  input  logic [4:0]        req_ra,
  input  logic              req_w,
  input  logic              req_wx,
  input  logic [6:0]        req_bits,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wi,
  input  logic              req_dce,
  input  logic [MSR_W-1:0]  req_msr,
  output logic              trap_now,
  output logic              exc_pulse,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [31:0]       syndrome,
  output logic [ADDR_W-1:0] handler_pc,
  output logic [MSR_W-1:0]  handler_msr
);
  localparam logic [MSR_W-1:0] CLR_M = MSR_W'(MSR_CLR);

  acc_class_t        cls;
  logic              misaligned;
  logic [31:0]       syn_next;
  logic              le_mode, strict_cls, decide;
  logic [MSR_W-1:0]  msr_next;

  align_classify u_cls (
    .prim(req_prim), .ext(req_ext), .w_sel(req_w), .wx_sel(req_wx),
    .bits(req_bits), .cls(cls)
  );

  align_misalign #(.ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES)) u_mis (
    .bits(req_bits), .addr(req_addr), .misaligned(misaligned)
  );

  align_syndrome #(.SYN_W(32)) u_syn (
    .prim(req_prim), .ext(req_ext), .rd(req_rd), .ra(req_ra), .syn(syn_next)
  );

  always_comb begin
    le_mode    = req_msr[LE_BIT];
    strict_cls = cls.fp || cls.multi || cls.rsv || cls.xctl;
    decide     = (cls.cbz && (req_wi || !req_dce)) ||
                 (strict_cls && misaligned) ||
                 (cls.multi && le_mode);
    trap_now   = req_valid && decide;
    msr_next          = req_msr & ~CLR_M;
    msr_next[LE_BIT]  = req_msr[ILE_BIT];
  end

  assign req_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_pulse   <= 1'b0;
      fault_addr  <= '0;
      syndrome    <= '0;
      handler_pc  <= '0;
      handler_msr <= '0;
    end else begin
      exc_pulse <= trap_now;
      if (trap_now) begin
        fault_addr  <= req_addr;
        syndrome    <= syn_next;
        handler_pc  <= ADDR_W'(VECTOR);
        handler_msr <= msr_next;
      end
    end
  end
endmodule

// File: rtl/align_exc_unit_chk.sv
module align_exc_unit_chk #(
  parameter int          ADDR_W = 32,
  parameter logic [31:0] VECTOR = 32'h0000_0600
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [9:0]        req_ext,
  input logic [6:0]        req_bits,
  input logic [31:0]       req_msr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              trap_now,
  input logic              exc_pulse,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [ADDR_W-1:0] handler_pc
);
  // R10
  pulse_follows_chk: assert property (@(posedge clk) disable iff (rst)
    trap_now |=> exc_pulse);
  // R10
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_now |=> !exc_pulse);
  // R7
  fault_capture_chk: assert property (@(posedge clk) disable iff (rst)
    trap_now |=> (fault_addr == $past(req_addr)));
  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_now |=> $stable(fault_addr));
  // R1
  byte_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (req_bits == 7'd8 && !req_msr[0] && req_ext != 10'd1014) |-> !trap_now);
  // R9
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    exc_pulse |-> (handler_pc == ADDR_W'(VECTOR)));
  // R12
  ready_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready);
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !trap_now);
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!exc_pulse && fault_addr == '0 && handler_pc == '0));
endmodule

bind align_exc_unit align_exc_unit_chk #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_ext(req_ext), .req_bits(req_bits), .req_msr(req_msr), .req_addr(req_addr),
  .trap_now(trap_now), .exc_pulse(exc_pulse), .fault_addr(fault_addr),
  .handler_pc(handler_pc)
);

// File: tb/align_exc_unit_test.sv
`timescale 1ns/1ps
module align_exc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_prim = '0;
  logic [9:0]  req_ext = '0;
  logic [4:0]  req_rd = '0, req_ra = '0;
  logic        req_w = 1'b0, req_wx = 1'b0;
  logic [6:0]  req_bits = 7'd8;
  logic [31:0] req_addr = '0;
  logic        req_wi = 1'b0, req_dce = 1'b1;
  logic [31:0] req_msr = '0;
  logic        trap_now, exc_pulse;
  logic [31:0] fault_addr, syndrome, handler_pc, handler_msr;

  int checks = 0, failures = 0;
  logic [31:0] m_fault = '0, m_syn = '0, m_pc = '0, m_msr = '0;

  always #2.5 clk = ~clk;

  align_exc_unit uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ps_ok(input int bits, input bit s);
    return (bits == 32 && s) || (bits == 64 && !s);
  endfunction

  function automatic bit model_trap(input int p, input int x, input bit w, input bit wx,
      input int bits, input logic [31:0] a, input bit wi, input bit dce, input bit le);
    int mask;
    bit fp, multi, rsv, xc, cbz, mis;
    mask  = (bits / 8 >= 4) ? 3 : bits / 8 - 1;
    mis   = (a & mask) != 0;
    fp    = (p >= 48 && p <= 55) || (p >= 56 && p <= 61 && ps_ok(bits, w)) ||
            (p == 4 && x != 1014 && ps_ok(bits, wx));
    multi = p == 46 || p == 47 || (p == 31 && (x == 533 || x == 597 || x == 661 || x == 725));
    rsv   = p == 31 && (x == 20 || x == 150);
    xc    = p == 31 && (x == 310 || x == 438);
    cbz   = x == 1014 && (p == 31 || p == 4);
    return (cbz && (wi || !dce)) || ((fp || multi || rsv || xc) && mis) || (multi && le);
  endfunction

  function automatic logic [31:0] model_syn(input int p, input int x, input int rd, input int ra);
    int op;
    op = (p >= 32) ? x : (p >> 1);
    return 32'(((op >> 8) << 15) | ((op & 31) << 10) | (rd << 5) | ra);
  endfunction

  function automatic logic [31:0] model_msr(input logic [31:0] m);
    logic [31:0] r;
    r = m & ~32'h0004_EF36;
    r[0] = m[16];
    return r;
  endfunction

  task automatic send(input string tag, input bit v, input int p, input int x, input bit w,
      input bit wx, input int bits, input logic [31:0] a, input bit wi, input bit dce,
      input logic [31:0] msr);
    bit et;
    logic [4:0] rd, ra;
    rd = 5'($urandom); ra = 5'($urandom);
    @(negedge clk);
    req_valid = v; req_prim = 6'(p); req_ext = 10'(x); req_w = w; req_wx = wx;
    req_bits = 7'(bits); req_addr = a; req_wi = wi; req_dce = dce; req_msr = msr;
    req_rd = rd; req_ra = ra;
    et = v && model_trap(p, x, w, wx, bits, a, wi, dce, msr[0]);
    #1;
    chk(trap_now == et, tag, 32'(trap_now), 32'(et));
    chk(req_ready == 1'b1, "R12", 32'(req_ready), 32'd1);
    if (et) begin
      m_fault = a; m_syn = model_syn(p, x, rd, ra); m_pc = 32'h600; m_msr = model_msr(msr);
    end
    @(posedge clk); #1;
    chk(exc_pulse == et, "R10", 32'(exc_pulse), 32'(et));
    chk(fault_addr == m_fault, "R7", fault_addr, m_fault);
    chk(syndrome == m_syn, "R8", syndrome, m_syn);
    chk(handler_pc == m_pc && handler_msr == m_msr, "R9", handler_msr, m_msr);
  endtask

  initial begin
    #(200000 * 5);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int prims[16] = '{31, 4, 46, 47, 48, 52, 55, 56, 59, 61, 32, 36, 44, 62, 0, 63};
    int exts[11]  = '{1014, 533, 597, 661, 725, 20, 150, 310, 438, 266, 0};
    int widths[4] = '{8, 16, 32, 64};
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(exc_pulse == 0 && fault_addr == 0 && syndrome == 0, "R11", fault_addr, 32'd0);
    chk(handler_pc == 0 && handler_msr == 0, "R11", handler_pc, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R1 widths
    send("R1", 1, 50, 0, 0, 0, 64, 32'h1004, 0, 1, 0);
    send("R1", 1, 48, 0, 0, 0, 8,  32'h1003, 0, 1, 0);
    send("R1", 1, 48, 0, 0, 0, 16, 32'h1001, 0, 1, 0);
    send("R1", 1, 48, 0, 0, 0, 16, 32'h1002, 0, 1, 0);
    // R2 classes
    send("R2", 1, 50, 0, 0, 0, 64, 32'h1002, 0, 1, 0);
    send("R2", 1, 32, 0, 0, 0, 32, 32'h2001, 0, 1, 0);
    send("R2", 1, 31, 20, 0, 0, 32, 32'h3003, 0, 1, 0);
    send("R2", 1, 31, 438, 0, 0, 32, 32'h3002, 0, 1, 0);
    send("R2", 1, 31, 661, 0, 0, 8, 32'h3001, 0, 1, 0);
    // R3 paired-single
    send("R3", 1, 56, 0, 1, 0, 32, 32'h4002, 0, 1, 0);
    send("R3", 1, 56, 0, 0, 0, 32, 32'h4002, 0, 1, 0);
    send("R3", 1, 4, 6, 0, 0, 64, 32'h4001, 0, 1, 0);
    send("R3", 1, 4, 6, 1, 1, 64, 32'h4001, 0, 1, 0);
    // R4 / R5 cache-block-zero
    send("R4", 1, 31, 1014, 0, 0, 32, 32'h5000, 1, 1, 0);
    send("R4", 1, 31, 1014, 0, 0, 32, 32'h5000, 0, 1, 0);
    send("R5", 1, 4, 1014, 0, 0, 32, 32'h5020, 0, 0, 32'h0001_0000);
    // R6 little-endian mode
    send("R6", 1, 46, 0, 0, 0, 32, 32'h6000, 0, 1, 32'hFFFF_FFFF);
    send("R6", 1, 48, 0, 0, 0, 32, 32'h6000, 0, 1, 32'h0000_0001);
    send("R6", 1, 31, 725, 0, 0, 32, 32'h6000, 0, 1, 32'h0000_0001);
    // R12 idle with a trapping pattern
    send("R12", 0, 31, 1014, 0, 0, 32, 32'h7001, 1, 0, 32'h1);

    for (int i = 0; i < 600; i++) begin
      int p, x, b;
      logic [31:0] a;
      p = prims[$urandom_range(15)];
      x = ($urandom_range(3) == 0) ? int'($urandom_range(1023)) : exts[$urandom_range(10)];
      b = widths[$urandom_range(3)];
      a = $urandom;
      send("R2", $urandom_range(4) != 0, p, x, 1'($urandom), 1'($urandom), b, a,
           1'($urandom), 1'($urandom_range(3) != 0), $urandom);
    end

    // R11 reset mid-run clears captures
    send("R2", 1, 50, 0, 0, 0, 64, 32'h1002, 0, 1, 0);
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    @(posedge clk); #1;
    chk(exc_pulse == 0 && fault_addr == 0 && syndrome == 0 && handler_msr == 0,
        "R11", fault_addr, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule